// File: doc/BRIEF.md
# Dual Down-Counter Timer with Interrupt Gating

This peripheral holds two 32-bit down-counters and a small interrupt cause/mask unit. All of them sit behind one register port with single-cycle write and read strobes. Each counter has its own enable and auto-reload bits in a shared control word, a reload register and a live count register. Counter 0 is usually set up as a free-running time base: it is loaded with all ones, auto-reload is on, and software reads its live count whenever it needs a timestamp. Counter 1 works either as a periodic tick (auto-reload on) or as a one-shot event timer (auto-reload off). In one-shot mode it disables itself once it has fired.

When a counter expires, its bit in the cause register is set. A mask register selects which cause bits drive the single interrupt output. Software acknowledges an event by writing a word to the cause register: every bit written as 0 is cleared, and every bit written as 1 is left alone. A handler can therefore clear one timer without disturbing the other. Read data and the interrupt output are both registered.

Top module: `dual_tmr_top`

## Requirements
- R1: A synchronous active-high reset clears the control, reload, count, cause and mask registers. It also drives `rdata` and `irq_o` to 0.
- R2: The control word is at 0x000. Bit 2i enables counter i and bit 2i+1 turns on auto-reload for counter i. Counter i's reload register is at 0x010+8i and its count register at 0x014+8i. With auto-reload on and both registers loaded with N-1, the counter expires once every N clocks.
- R3: With auto-reload off, write D (D >= 1) to the count register, then set the enable bit. The counter expires exactly once, and `irq_o` (with its mask bit set) first reads 1 at the D+2nd rising edge after the edge that captured the enable. The enable bit clears itself and no further event follows.
- R4: Counter 0 loaded with 0xFFFFFFFF and auto-reload on runs as a wrapping 32-bit counter. Its live count, read at any time, falls by exactly one per clock. After it passes zero it continues from the reload value and sets cause bit 1.
- R5: Cause and mask are at 0x110 and 0x114, with counter i at bit i+1 (counter 0 at bit 1, counter 1 at bit 2). `irq_o` becomes, one clock later, the OR over the timers of cause AND mask. It stays 0 for a masked timer even when that timer's cause bit is set.
- R6: A write to the cause register clears each cause bit written as 0 and keeps each bit written as 1. Apart from such a write, a cause bit never falls.
- R7: If an expiry and a clearing write to the same cause bit happen in the same cycle, the bit stays set.
- R8: A write to a count register sets the count on the next edge. It replaces that cycle's decrement or reload, and it suppresses an expiry in that cycle.
- R9: A read strobe captures, on the next edge, the register at `addr`: the reload value, the live count, the control word, or cause/mask in bits 1..2. Unmapped addresses read as 0. `rdata` holds its value while no read is strobed.
- R10: An enabled counter whose count is not zero decrements by one per clock. A disabled counter holds its count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| rd_en | input | 1 | Read strobe; `rdata` updates on the next edge |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench goes after the places where an off-by-one or a wrong priority would stay hidden. These are:
- The periodic interval. Reloading one cycle late would stretch the period to N+1.
- The one-shot latency and the self-disable. A counter that kept its enable would fire again at every wrap.
- The cause write that races an expiry. Giving the clear priority would silently drop an event.
- The write-zero-to-clear semantics. A design that cleared on 1 would acknowledge the wrong timer.

It also checks that a masked cause never reaches `irq_o`, and that a count written while running is read back unchanged on the next cycle. A reference model that runs clock by clock catches any drift in `rdata` or `irq_o` between these targeted checks.

// File: rtl/dual_tmr_pkg.sv
package dual_tmr_pkg;
  localparam int CTRL_OFF  = 'h000;
  localparam int CAUSE_OFF = 'h110;
  localparam int MASK_OFF  = 'h114;

  // per-timer register stride of 8 bytes starting at 0x010
  function automatic int rld_off(input int idx);
    return 'h010 + 8 * idx;
  endfunction

  function automatic int cnt_off(input int idx);
    return 'h014 + 8 * idx;
  endfunction
endpackage

// File: rtl/dual_tmr_ctr.sv
module dual_tmr_ctr #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              autoload_i,
  input  logic [DATA_W-1:0] reload_i,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] ld_data_i,
  output logic [DATA_W-1:0] count_o,
  output logic              expire_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] count_q;
  logic              at_zero;

  assign at_zero  = (count_q == '0);
  assign expire_o = run_i && at_zero && !ld_i;
  assign count_o  = count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (ld_i) begin
      count_q <= ld_data_i;
    end else if (run_i) begin
      if (at_zero) begin
        if (autoload_i) count_q <= reload_i;
      end else begin
        count_q <= count_q - ONE;
      end
    end
  end
endmodule

// File: rtl/dual_tmr_irq.sv
module dual_tmr_irq #(
  parameter int N_TMR = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cause_we,
  input  logic             mask_we,
  input  logic [N_TMR-1:0] keep_i,
  input  logic [N_TMR-1:0] set_i,
  output logic [N_TMR-1:0] cause_o,
  output logic [N_TMR-1:0] mask_o,
  output logic             irq_o
);
  logic [N_TMR-1:0] cause_q, mask_q;
  logic             irq_q;
  logic [N_TMR-1:0] cause_kept;

  // write-zero-to-clear; a new expiry always overrides the clear
  assign cause_kept = cause_we ? (cause_q & keep_i) : cause_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      mask_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      cause_q <= cause_kept | set_i;
      if (mask_we) mask_q <= keep_i;
      irq_q   <= |(cause_q & mask_q);
    end
  end

  assign cause_o = cause_q;
  assign mask_o  = mask_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/dual_tmr_top.sv
module dual_tmr_top
  import dual_tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int N_TMR  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_o
);
  localparam int CTRL_W = 2 * N_TMR;

  logic [CTRL_W-1:0]             ctrl_q;
  logic [N_TMR-1:0][DATA_W-1:0]  rld_q;
  logic [N_TMR-1:0][DATA_W-1:0]  cnt_all;
  logic [N_TMR-1:0]              expire;
  logic [N_TMR-1:0]              cause_w, mask_w;
  logic [DATA_W-1:0]             rd_d, rdata_q;
  logic                          ctrl_we, cause_we, mask_we;

  assign ctrl_we  = wr_en && (addr == ADDR_W'(CTRL_OFF));
  assign cause_we = wr_en && (addr == ADDR_W'(CAUSE_OFF));
  assign mask_we  = wr_en && (addr == ADDR_W'(MASK_OFF));

  // shared control word: enables self-clear on one-shot expiry
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= wdata[CTRL_W-1:0];
    end else begin
      for (int i = 0; i < N_TMR; i++) begin
        if (expire[i] && !ctrl_q[2*i+1]) ctrl_q[2*i] <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    logic rld_we, cnt_we;
    assign rld_we = wr_en && (addr == ADDR_W'(rld_off(g)));
    assign cnt_we = wr_en && (addr == ADDR_W'(cnt_off(g)));

    always_ff @(posedge clk) begin
      if (rst)         rld_q[g] <= '0;
      else if (rld_we) rld_q[g] <= wdata;
    end

    dual_tmr_ctr #(.DATA_W(DATA_W)) u_ctr (
      .clk        (clk),
      .rst        (rst),
      .run_i      (ctrl_q[2*g]),
      .autoload_i (ctrl_q[2*g+1]),
      .reload_i   (rld_q[g]),
      .ld_i       (cnt_we),
      .ld_data_i  (wdata),
      .count_o    (cnt_all[g]),
      .expire_o   (expire[g])
    );
  end

  dual_tmr_irq #(.N_TMR(N_TMR)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .cause_we (cause_we),
    .mask_we  (mask_we),
    .keep_i   (wdata[N_TMR:1]),
    .set_i    (expire),
    .cause_o  (cause_w),
    .mask_o   (mask_w),
    .irq_o    (irq_o)
  );

  always_comb begin
    rd_d = '0;
    if (addr == ADDR_W'(CTRL_OFF))  rd_d[CTRL_W-1:0] = ctrl_q;
    if (addr == ADDR_W'(CAUSE_OFF)) rd_d[N_TMR:1]    = cause_w;
    if (addr == ADDR_W'(MASK_OFF))  rd_d[N_TMR:1]    = mask_w;
    for (int i = 0; i < N_TMR; i++) begin
      if (addr == ADDR_W'(rld_off(i))) rd_d = rld_q[i];
      if (addr == ADDR_W'(cnt_off(i))) rd_d = cnt_all[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_d;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/dual_tmr_chk.sv
module dual_tmr_chk
  import dual_tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int N_TMR  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              irq_o,
  input logic [2*N_TMR-1:0] ctrl,
  input logic [N_TMR-1:0]  cause,
  input logic [N_TMR-1:0]  mask,
  input logic [DATA_W-1:0] cnt1,
  input logic [DATA_W-1:0] rld1
);
  logic cnt1_we, cause_we;
  assign cnt1_we  = wr_en && (addr == ADDR_W'(cnt_off(1)));
  assign cause_we = wr_en && (addr == ADDR_W'(CAUSE_OFF));

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!irq_o && ctrl == '0 && cause == '0 && mask == '0));

  assert_reload_R2: assert property (@(posedge clk) disable iff (rst)
    (ctrl[2] && ctrl[3] && cnt1 == '0 && !wr_en) |=> (cnt1 == $past(rld1)));

  assert_oneshot_stop_R3: assert property (@(posedge clk) disable iff (rst)
    (ctrl[2] && !ctrl[3] && cnt1 == '0 && !wr_en) |=> !ctrl[2]);

  assert_irq_masked_R5: assert property (@(posedge clk) disable iff (rst)
    ((cause & mask) == '0) |=> !irq_o);

  assert_cause_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    !cause_we |=> ((cause & $past(cause)) == $past(cause)));

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (ctrl[2] && cnt1 == '0 && !cnt1_we) |=> cause[1]);

  assert_value_load_R8: assert property (@(posedge clk) disable iff (rst)
    cnt1_we |=> (cnt1 == $past(wdata)));

  assert_count_down_R10: assert property (@(posedge clk) disable iff (rst)
    (ctrl[2] && cnt1 != '0 && !wr_en) |=> (cnt1 == $past(cnt1) - DATA_W'(1)));
endmodule

bind dual_tmr_top dual_tmr_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .N_TMR  (N_TMR)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .wr_en (wr_en),
  .addr  (addr),
  .wdata (wdata),
  .irq_o (irq_o),
  .ctrl  (ctrl_q),
  .cause (cause_w),
  .mask  (mask_w),
  .cnt1  (cnt_all[1]),
  .rld1  (rld_q[1])
);

// File: tb/dual_tmr_top_tb.sv
module dual_tmr_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_CTRL = 12'h000, A_RLD0 = 12'h010, A_VAL0 = 12'h014,
                          A_RLD1 = 12'h018, A_VAL1 = 12'h01C,
                          A_CAUSE = 12'h110, A_MASK = 12'h114;

  logic        clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o;

  dual_tmr_top u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  logic [31:0] m_cnt [2];
  logic [31:0] m_rld [2];
  logic [31:0] m_ctrl, m_cause, m_mask, m_rdata;
  logic        m_irq;

  int    vectors = 0, miscompares = 0, cyc = 0;
  string tag = "R1";
  bit    done = 0;

  function automatic logic [31:0] mread(input logic [11:0] a);
    case (a)
      A_CTRL:  return m_ctrl;
      A_RLD0:  return m_rld[0];
      A_VAL0:  return m_cnt[0];
      A_RLD1:  return m_rld[1];
      A_VAL1:  return m_cnt[1];
      A_CAUSE: return m_cause;
      A_MASK:  return m_mask;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_update(input logic we, input logic re,
                              input logic [11:0] a, input logic [31:0] d);
    logic [31:0] n_cnt [2];
    logic [31:0] n_rld [2];
    logic [31:0] n_ctrl, n_cause, n_mask, n_rdata;
    logic [1:0]  ex;
    logic        n_irq;
    if (rst) begin
      for (int i = 0; i < 2; i++) begin m_cnt[i] = 0; m_rld[i] = 0; end
      m_ctrl = 0; m_cause = 0; m_mask = 0; m_rdata = 0; m_irq = 0;
      return;
    end
    n_rdata = re ? mread(a) : m_rdata;
    n_irq   = |(m_cause & m_mask);
    n_ctrl  = m_ctrl;
    for (int i = 0; i < 2; i++) begin
      logic wv, en, ar;
      wv = we && (a == 12'(20 + 8*i));
      en = m_ctrl[2*i];
      ar = m_ctrl[2*i+1];
      ex[i] = en && (m_cnt[i] == 0) && !wv;
      if (wv)                n_cnt[i] = d;
      else if (!en)          n_cnt[i] = m_cnt[i];
      else if (m_cnt[i] == 0) n_cnt[i] = ar ? m_rld[i] : 32'h0;
      else                   n_cnt[i] = m_cnt[i] - 1;
      n_rld[i] = (we && a == 12'(16 + 8*i)) ? d : m_rld[i];
      if (ex[i] && !ar) n_ctrl[2*i] = 1'b0;
    end
    if (we && a == A_CTRL) n_ctrl = d & 32'hF;
    n_cause = ((we && a == A_CAUSE) ? (m_cause & d) : m_cause) | {29'b0, ex, 1'b0};
    n_cause = n_cause & 32'h6;
    n_mask  = (we && a == A_MASK) ? (d & 32'h6) : m_mask;
    for (int i = 0; i < 2; i++) begin m_cnt[i] = n_cnt[i]; m_rld[i] = n_rld[i]; end
    m_ctrl = n_ctrl; m_cause = n_cause; m_mask = n_mask; m_rdata = n_rdata; m_irq = n_irq;
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h (cycle %0d)", req, what, got, exp, cyc);
    end
  endtask

  task automatic step(input logic we, input logic re,
                      input logic [11:0] a, input logic [31:0] d);
    wr_en = we; rd_en = re; addr = a; wdata = d;
    @(posedge clk);
    model_update(we, re, a, d);
    @(negedge clk);
    cyc++;
    check(tag, "rdata vs model", rdata, m_rdata);
    check(tag, "irq_o vs model", {31'b0, irq_o}, {31'b0, m_irq});
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    step(1'b1, 1'b0, a, d);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    step(1'b0, 1'b1, a, 32'h0);
    v = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 12'h0, 32'h0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [31:0] v, v2;
    int          rises [4];
    int          n;
    bit          seen;

    // R1: reset state
    tag = "R1";
    idle(3);
    rst = 1'b0;
    rd(A_CTRL, v);  check("R1", "ctrl after reset", v, 32'h0);
    rd(A_VAL1, v);  check("R1", "count1 after reset", v, 32'h0);
    rd(A_CAUSE, v); check("R1", "cause after reset", v, 32'h0);
    check("R1", "irq after reset", {31'b0, irq_o}, 32'h0);

    // R2: periodic counter 1 with N = 5
    tag = "R2";
    wr(A_RLD1, 32'd4); wr(A_VAL1, 32'd4); wr(A_MASK, 32'h4); wr(A_CTRL, 32'hC);
    for (int k = 0; k < 4; k++) begin
      n = 0;
      do begin idle(1); n++; end while (irq_o == 1'b0 && n < 40);
      rises[k] = cyc;
      wr(A_CAUSE, 32'hFFFF_FFFB);
    end
    for (int k = 1; k < 4; k++)
      check("R2", "periodic interval", 32'(rises[k] - rises[k-1]), 32'd5);
    wr(A_CTRL, 32'h0); wr(A_CAUSE, 32'h0); idle(2);

    // R10: disabled counter holds
    tag = "R10";
    rd(A_VAL1, v); idle(4); rd(A_VAL1, v2);
    check("R10", "disabled count holds", v2, v);

    // R3: one-shot D = 7
    tag = "R3";
    wr(A_VAL1, 32'd7); wr(A_CTRL, 32'h4);
    n = 0;
    do begin idle(1); n++; end while (irq_o == 1'b0 && n < 50);
    check("R3", "one-shot latency D+2", 32'(n), 32'd9);
    rd(A_CTRL, v); check("R3", "enable self-cleared", v, 32'h0);
    wr(A_CAUSE, 32'h0);
    idle(1);
    seen = 0;
    for (int k = 0; k < 30; k++) begin idle(1); if (irq_o) seen = 1; end
    check("R3", "no second one-shot event", {31'b0, seen}, 32'h0);

    // R4: free-running counter 0
    tag = "R4";
    wr(A_MASK, 32'h0);
    wr(A_RLD0, 32'hFFFF_FFFF); wr(A_VAL0, 32'hFFFF_FFFF); wr(A_CTRL, 32'h3);
    idle(3);
    rd(A_VAL0, v);  check("R4", "live count read", v, 32'hFFFF_FFFC);
    idle(10);
    rd(A_VAL0, v2); check("R4", "count drop over 11 clocks", v - v2, 32'd11);
    wr(A_VAL0, 32'd2); idle(3);
    rd(A_VAL0, v);  check("R4", "wrap to reload value", v, 32'hFFFF_FFFF);
    rd(A_CAUSE, v); check("R4", "wrap sets cause bit 1", v, 32'h2);

    // R5: masked cause does not reach irq_o
    tag = "R5";
    check("R5", "irq low while masked", {31'b0, irq_o}, 32'h0);
    wr(A_MASK, 32'h2); idle(1);
    check("R5", "irq high once unmasked", {31'b0, irq_o}, 32'h1);
    rd(A_MASK, v); check("R5", "mask readback", v, 32'h2);

    // R6: selective write-zero-to-clear
    tag = "R6";
    wr(A_MASK, 32'h0);
    wr(A_VAL1, 32'd1); wr(A_CTRL, 32'h4); idle(5);
    rd(A_CAUSE, v); check("R6", "both cause bits set", v, 32'h6);
    wr(A_CAUSE, 32'hFFFF_FFFB);
    rd(A_CAUSE, v); check("R6", "only bit 2 cleared", v, 32'h2);
    wr(A_CAUSE, 32'hFFFF_FFFD);
    rd(A_CAUSE, v); check("R6", "bit 1 cleared", v, 32'h0);

    // R7: expiry and clear in the same cycle
    tag = "R7";
    wr(A_VAL1, 32'd3); wr(A_CTRL, 32'h4); idle(3);
    wr(A_CAUSE, 32'h0);
    rd(A_CAUSE, v); check("R7", "expiry beats clear", v, 32'h4);
    wr(A_CAUSE, 32'h0);

    // R8 / R9: count override and readback
    tag = "R8";
    wr(A_RLD1, 32'd100); wr(A_VAL1, 32'd50); wr(A_CTRL, 32'hC); idle(5);
    wr(A_VAL1, 32'd20);
    rd(A_VAL1, v); check("R8", "written count read next cycle", v, 32'd20);
    tag = "R9";
    rd(A_RLD1, v);   check("R9", "reload readback", v, 32'd100);
    rd(A_CTRL, v);   check("R9", "control readback", v, 32'hC);
    rd(12'h020, v);  check("R9", "unmapped reads zero", v, 32'h0);
    idle(3);
    check("R9", "rdata held without read", rdata, 32'h0);

    // R1: reset while running
    tag = "R1";
    rst = 1'b1; idle(2); rst = 1'b0;
    rd(A_CTRL, v); check("R1", "ctrl cleared by reset", v, 32'h0);
    rd(A_RLD1, v); check("R1", "reload cleared by reset", v, 32'h0);

    finish_run();
  end
endmodule